// File: doc/BRIEF.md
# Source-Matched Receive Buffer

This block sits between a cluster bus and the input port of a small processor core. Every word that arrives from the bus is written into a 32-slot store together with the number of the core that sent it. Slots are kept in arrival order, so slot 0 always holds the oldest word still waiting.

When the core executes a receive that names a sending core, it raises a request and holds it together with the wanted sender number. A search machine then walks the store one slot per clock, starting at the oldest word. The first word whose sender field equals the wanted number is handed to the core, and its slot is freed. Every younger word moves down one slot, so arrival order is kept. Words from other senders stay where they are. If no stored word matches, the machine reports a miss and waits. The core stays stalled until a word is delivered. The next word the bus writes makes the machine scan again from the oldest slot.

Top module: `src_match_rxbuf`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty: `buf_empty`=1, `buf_full`=0, `wr_ready`=1, `rd_valid`=0 and `rd_miss`=0.
- R2: A bus write is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. The word and its sender number are stored and can later be delivered unchanged.
- R3: `wr_ready` is 0 while 32 words are held. A write offered then is dropped and is never delivered.
- R4: A receive delivers only a word whose stored sender field equals `rd_src`. Words from other senders stay in the buffer.
- R5: When several stored words match, the oldest of them is delivered first.
- R6: Suppose a request is raised while the machine is idle, and the first match sits at position k (0 = oldest). Then `rd_valid` is high in the (k+2)-th cycle after the edge that first sees the request.
- R7: `rd_valid` is a single-cycle pulse that carries the word on `rd_data`. The delivered word leaves the buffer, and the remaining words keep their relative order.
- R8: If the scan passes the youngest word without a match, `rd_miss` is raised and the request stays pending. The next accepted write restarts the scan at the oldest word.
- R9: A write and a removal in the same cycle both take effect.
- R10: Dropping `rd_req` before delivery abandons the search, and no word is removed.
- R11: `buf_empty` is 1 exactly when no word is held, and `buf_full` is 1 exactly when 32 words are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Bus offers a word |
| wr_src | input | 2 | Number of the sending core |
| wr_data | input | 16 | Offered data word |
| wr_ready | output | 1 | Buffer can take a word this cycle |
| rd_req | input | 1 | Core is waiting in a receive; held until `rd_valid` |
| rd_src | input | 2 | Sender the receive asks for; stable while `rd_req` is high |
| rd_valid | output | 1 | One-cycle pulse: word delivered |
| rd_data | output | 16 | Delivered word, valid with `rd_valid` |
| rd_miss | output | 1 | Scan ended without a match; still waiting |
| buf_empty | output | 1 | No word held |
| buf_full | output | 1 | All 32 slots held |

## Verification
Suppose compaction goes wrong, for example a slot is skipped or duplicated. That shows on `rd_data` at the next delivery that touches the damaged slot, because the word differs from the one the arrival order predicts. A wrong count shows at once on `buf_empty`, `buf_full` or `wr_ready`. A wrong scan pointer or a wrong machine state moves the `rd_valid` pulse away from its predicted cycle, or raises `rd_miss` too early or too late, within one scan length. The bench keeps a queue model that predicts each of these outputs and compares them on every clock, so such a fault is reported in the cycle it first becomes visible.

// File: rtl/rxb_pkg.sv
// Package: shared types of the source-matched receive buffer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package rxb_pkg;

    // States of the search machine
    typedef enum logic [1:0] {
        SK_IDLE = 2'd0,
        SK_SCAN = 2'd1,
        SK_WAIT = 2'd2
    } seek_state_t;

endpackage

// File: rtl/rxb_store.sv
// Module: ordered word store with single-slot removal and compaction.
// Slot 0 holds the oldest word. Removing slot r shifts every younger slot
// down by one. A write in the same cycle lands behind the last live word.
// Assumes: wr_en is never asserted while full, and rm_idx < count when rm_en.
module rxb_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16,
    parameter int SRC_W  = 2,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [SRC_W-1:0]                   wr_src,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               rm_en,
    input  logic [CNT_W-1:0]                   rm_idx,
    output logic [DEPTH-1:0][SRC_W-1:0]        src_vec,
    output logic [DEPTH-1:0][DATA_W-1:0]       data_vec,
    output logic [CNT_W-1:0]                   count
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [DEPTH-1:0][SRC_W-1:0]  src_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;
    logic [DEPTH-1:0][SRC_W-1:0]  src_d;
    logic [DEPTH-1:0][DATA_W-1:0] data_d;
    logic [CNT_W-1:0]             count_q;

    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        localparam logic [CNT_W-1:0] J = CNT_W'(j);
        logic [SRC_W-1:0]  up_src;
        logic [DATA_W-1:0] up_data;

        if (j < DEPTH - 1) begin : g_up
            assign up_src  = src_q[j+1];
            assign up_data = data_q[j+1];
        end else begin : g_top
            assign up_src  = '0;
            assign up_data = '0;
        end

        // Next content of slot j: keep, shift down, or take the new word
        always_comb begin
            src_d[j]  = src_q[j];
            data_d[j] = data_q[j];
            if (rm_en && (J >= rm_idx)) begin
                if ((J + 1'b1) < count_q) begin
                    src_d[j]  = up_src;
                    data_d[j] = up_data;
                end else if (wr_en && (J == count_q - 1'b1)) begin
                    src_d[j]  = wr_src;
                    data_d[j] = wr_data;
                end
            end else if (wr_en && !rm_en && (J == count_q)) begin
                src_d[j]  = wr_src;
                data_d[j] = wr_data;
            end
        end
    end

    // Register the slot contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            data_q <= '0;
        end else begin
            src_q  <= src_d;
            data_q <= data_d;
        end
    end

    // Track the number of live words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + CNT_W'(wr_en) - CNT_W'(rm_en);
        end
    end

    assign src_vec  = src_q;
    assign data_vec = data_q;
    assign count    = count_q;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (count_q < DEPTH_C));

    // R11
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= DEPTH_C);

    // R9
    count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count_q == $past(count_q) + CNT_W'($past(wr_en)) - CNT_W'($past(rm_en))));

    // R7
    rm_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rm_en |-> (rm_idx < count_q));

endmodule

// File: rtl/rxb_match.sv
// Module: per-slot comparison of the stored sender field against a key.
// A slot reports a hit only if it holds a live word.
// Assumes: count never exceeds DEPTH.
module rxb_match #(
    parameter int DEPTH = 32,
    parameter int SRC_W = 2,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][SRC_W-1:0] src_vec,
    input  logic [CNT_W-1:0]            count,
    input  logic [SRC_W-1:0]            key,
    output logic [DEPTH-1:0]            hit_vec
);

    for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
        localparam logic [CNT_W-1:0] J = CNT_W'(j);
        // Slot j is live and carries the wanted sender
        assign hit_vec[j] = (J < count) && (src_vec[j] == key);
    end

endmodule

// File: rtl/rxb_seek.sv
// Module: search machine. It walks the store one slot per clock from the
// oldest word, removes and delivers the first hit, and otherwise waits
// for a new word and rescans from slot 0.
// Assumes: rd_src of the requester is stable while its request is high.
module rxb_seek
    import rxb_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_req,
    input  logic [DEPTH-1:0]             hit_vec,
    input  logic [DEPTH-1:0][DATA_W-1:0] data_vec,
    input  logic [CNT_W-1:0]             count,
    input  logic                         wr_en,
    output logic                         rm_en,
    output logic [CNT_W-1:0]             rm_idx,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_miss
);

    localparam int IDX_W = $clog2(DEPTH);

    seek_state_t       state_q;
    logic [CNT_W-1:0]  ptr_q;
    logic              cur_in;
    logic              cur_hit;
    logic [IDX_W-1:0]  slot;

    // Examine the slot under the pointer
    always_comb begin
        slot    = ptr_q[IDX_W-1:0];
        cur_in  = ptr_q < count;
        cur_hit = cur_in && hit_vec[slot];
        rm_en   = (state_q == SK_SCAN) && rd_req && cur_hit;
        rm_idx  = ptr_q;
    end

    // Step the search machine and register the delivered word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SK_IDLE;
            ptr_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state_q)
                SK_IDLE: begin
                    if (rd_req && !rd_valid) begin
                        state_q <= SK_SCAN;
                        ptr_q   <= '0;
                    end
                end
                SK_SCAN: begin
                    if (!rd_req) begin
                        state_q <= SK_IDLE;
                    end else if (!cur_in) begin
                        if (!wr_en) state_q <= SK_WAIT;
                    end else if (cur_hit) begin
                        rd_valid <= 1'b1;
                        rd_data  <= data_vec[slot];
                        state_q  <= SK_IDLE;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                SK_WAIT: begin
                    if (!rd_req) begin
                        state_q <= SK_IDLE;
                    end else if (wr_en) begin
                        state_q <= SK_SCAN;
                        ptr_q   <= '0;
                    end
                end
                default: state_q <= SK_IDLE;
            endcase
        end
    end

    assign rd_miss = (state_q == SK_WAIT);

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6
    rm_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rm_en |=> rd_valid);

    // R8
    miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !rd_miss);

    // R10
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && rd_valid |-> $past(rd_req));

endmodule

// File: rtl/src_match_rxbuf.sv
// Module: receive buffer for one core. Bus words are stored with their
// sender number. A receive is served by the oldest word from the
// requested sender.
// Assumes: rd_req and rd_src are held until rd_valid, or rd_req is dropped
// to abandon the receive.
module src_match_rxbuf #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16,
    parameter int SRC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [SRC_W-1:0]  wr_src,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_req,
    input  logic [SRC_W-1:0]  rd_src,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_miss,
    output logic              buf_empty,
    output logic              buf_full
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [DEPTH-1:0][SRC_W-1:0]  src_vec;
    logic [DEPTH-1:0][DATA_W-1:0] data_vec;
    logic [CNT_W-1:0]             count;
    logic [DEPTH-1:0]             hit_vec;
    logic                         wr_en;
    logic                         rm_en;
    logic [CNT_W-1:0]             rm_idx;
    logic [DEPTH-1:0]             older_mask;

    // Bus handshake and level flags
    always_comb begin
        buf_full   = (count == DEPTH_C);
        buf_empty  = (count == '0);
        wr_ready   = !buf_full;
        wr_en      = wr_valid && wr_ready;
        older_mask = (DEPTH'(1) << rm_idx[$clog2(DEPTH)-1:0]) - DEPTH'(1);
    end

    rxb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_src   (wr_src),
        .wr_data  (wr_data),
        .rm_en    (rm_en),
        .rm_idx   (rm_idx),
        .src_vec  (src_vec),
        .data_vec (data_vec),
        .count    (count)
    );

    rxb_match #(.DEPTH(DEPTH), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_match (
        .src_vec (src_vec),
        .count   (count),
        .key     (rd_src),
        .hit_vec (hit_vec)
    );

    rxb_seek #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seek (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .hit_vec  (hit_vec),
        .data_vec (data_vec),
        .count    (count),
        .wr_en    (wr_en),
        .rm_en    (rm_en),
        .rm_idx   (rm_idx),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_miss  (rd_miss)
    );

    // R4
    rm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rm_en |-> (src_vec[rm_idx[$clog2(DEPTH)-1:0]] == rd_src));

    // R5
    oldest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rm_en |-> ((hit_vec & older_mask) == '0));

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_empty && buf_full));

endmodule

// File: tb/tb_src_match_rxbuf.sv
module tb_src_match_rxbuf;

    localparam int DEPTH  = 32;
    localparam int DATA_W = 16;
    localparam int SRC_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [SRC_W-1:0]  wr_src = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_ready;
    logic              rd_req = 1'b0;
    logic [SRC_W-1:0]  rd_src = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              rd_miss;
    logic              buf_empty;
    logic              buf_full;

    src_match_rxbuf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SRC_W(SRC_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_src(wr_src), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_req(rd_req), .rd_src(rd_src), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_miss(rd_miss), .buf_empty(buf_empty), .buf_full(buf_full)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;
    string phase_tag = "R1";
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    typedef struct { logic [SRC_W-1:0] s; logic [DATA_W-1:0] d; } ent_t;
    ent_t q[$];
    int   m_mode = 0;          // 0 idle, 1 scanning, 2 waiting
    int   m_pos = 0;
    bit   e_valid = 1'b0;
    logic [DATA_W-1:0] e_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_mode = 0; m_pos = 0; e_valid = 1'b0;
        end else begin
            bit acc;
            bit nv;
            acc = wr_valid && (q.size() < DEPTH);
            nv  = 1'b0;
            case (m_mode)
                0: if (rd_req && !e_valid) begin m_mode = 1; m_pos = 0; end
                1: begin
                    if (!rd_req) m_mode = 0;
                    else if (m_pos >= q.size()) begin
                        if (!acc) m_mode = 2;
                    end else if (q[m_pos].s == rd_src) begin
                        nv = 1'b1;
                        e_data = q[m_pos].d;
                        q.delete(m_pos);
                        m_mode = 0;
                    end else m_pos++;
                end
                default: begin
                    if (!rd_req) m_mode = 0;
                    else if (acc) begin m_mode = 1; m_pos = 0; end
                end
            endcase
            if (acc) begin
                ent_t e;
                e.s = wr_src; e.d = wr_data;
                q.push_back(e);
            end
            e_valid = nv;
        end
    end

    // Compare every port against the reference once per cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(wr_ready == (q.size() < DEPTH), "R3 wr_ready", wr_ready, q.size() < DEPTH);
            check(buf_full == (q.size() == DEPTH), "R11 buf_full", buf_full, q.size() == DEPTH);
            check(buf_empty == (q.size() == 0), "R11 buf_empty", buf_empty, q.size() == 0);
            check(rd_miss == (m_mode == 2), "R8 rd_miss", rd_miss, m_mode == 2);
            check(rd_valid == e_valid, {phase_tag, " rd_valid"}, rd_valid, e_valid);
            if (e_valid) check(rd_data == e_data, {phase_tag, " rd_data"}, rd_data, e_data);
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic put(input logic [SRC_W-1:0] s, input logic [DATA_W-1:0] d);
        bit acc;
        wr_valid = 1'b1; wr_src = s; wr_data = d;
        forever begin
            acc = wr_ready;
            step();
            if (acc) break;
        end
        wr_valid = 1'b0;
    endtask

    task automatic recv(input logic [SRC_W-1:0] s, input int max_wait,
                        output int lat, output bit got, output logic [DATA_W-1:0] val);
        rd_src = s; rd_req = 1'b1; lat = 0; got = 1'b0; val = '0;
        while (lat < max_wait) begin
            step();
            lat++;
            if (rd_valid) begin got = 1'b1; val = rd_data; break; end
        end
        rd_req = 1'b0;
    endtask

    int unsigned seed = 32'h1234_5678;
    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    initial begin
        int lat;
        bit got;
        logic [DATA_W-1:0] v;

        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        check(buf_empty == 1 && buf_full == 0 && wr_ready == 1 && rd_valid == 0 && rd_miss == 0,
              "R1 reset outputs", {buf_empty, buf_full, wr_ready, rd_valid, rd_miss}, 5'b10100);

        // R2 / R4 / R5 / R6 / R7: mixed senders
        phase_tag = "R2";
        put(2'd0, 16'h1000); put(2'd1, 16'h1101); put(2'd2, 16'h1202);
        put(2'd1, 16'h1103); put(2'd0, 16'h1004);
        phase_tag = "R6";
        recv(2'd2, 20, lat, got, v);
        check(got && lat == 4, "R6 latency for k=2", lat, 4);
        check(v == 16'h1202, "R2 stored word delivered", v, 16'h1202);
        phase_tag = "R5";
        recv(2'd1, 20, lat, got, v);
        check(v == 16'h1101, "R5 oldest match first", v, 16'h1101);
        phase_tag = "R7";
        recv(2'd1, 20, lat, got, v);
        check(v == 16'h1103, "R7 order kept after removal", v, 16'h1103);
        phase_tag = "R4";
        recv(2'd0, 20, lat, got, v);
        check(v == 16'h1000, "R4 other senders skipped", v, 16'h1000);
        recv(2'd0, 20, lat, got, v);
        check(v == 16'h1004, "R4 second sender-0 word", v, 16'h1004);
        check(buf_empty == 1, "R11 empty after drain", buf_empty, 1);

        // R8: miss then restart on new write
        phase_tag = "R8";
        rd_src = 2'd3; rd_req = 1'b1;
        repeat (3) step();
        check(rd_miss == 1, "R8 miss raised", rd_miss, 1);
        put(2'd3, 16'h3333);
        got = 1'b0;
        for (int i = 0; i < 5 && !got; i++) begin
            if (rd_valid) begin got = 1'b1; v = rd_data; end
            else step();
        end
        check(got && v == 16'h3333, "R8 restart finds new word", v, 16'h3333);
        rd_req = 1'b0;
        step();

        // R3 / R11: fill to capacity, refused write
        phase_tag = "R3";
        for (int j = 0; j < DEPTH; j++) put(2'(j % 3), 16'h2000 + 16'(j));
        check(buf_full == 1 && wr_ready == 0, "R3 full blocks writes", {buf_full, wr_ready}, 2'b10);
        wr_valid = 1'b1; wr_src = 2'd3; wr_data = 16'hBAD1;
        step();
        wr_valid = 1'b0;
        phase_tag = "R10";
        recv(2'd3, 40, lat, got, v);
        check(!got, "R3 refused word never delivered", got, 0);
        step();
        check(buf_full == 1, "R10 abandoned search removes nothing", buf_full, 1);
        recv(2'd2, 20, lat, got, v);
        check(got && v == 16'h2002, "R10 next receive after abort", v, 16'h2002);

        // R9: writes stream while a receive completes
        phase_tag = "R9";
        fork
            recv(2'd1, 80, lat, got, v);
            begin
                for (int i = 0; i < 12; i++) begin
                    wr_valid = 1'b1; wr_src = 2'(i % 2); wr_data = 16'h9000 + 16'(i);
                    step();
                end
                wr_valid = 1'b0;
            end
        join
        check(got && v == 16'h2001, "R9 delivery during writes", v, 16'h2001);

        // Mixed random traffic
        phase_tag = "R4";
        begin
            int waitc = 0;
            for (int c = 0; c < 4000; c++) begin
                wr_valid = (rnd() % 100) < 35;
                wr_src   = 2'(rnd());
                wr_data  = 16'(rnd());
                if (rd_req) begin
                    waitc++;
                    if (rd_valid || waitc > 70) rd_req = 1'b0;
                end else if ((rnd() % 100) < 25) begin
                    rd_src = 2'(rnd()); rd_req = 1'b1; waitc = 0;
                end
                step();
            end
        end
        wr_valid = 1'b0; rd_req = 1'b0;
        repeat (3) step();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule